// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Scheduler

This block sits beside the command sequencer of a two-bank SDRAM controller and decides when initialisation commands and periodic auto refreshes are due. After reset it walks the part through its power-up sequence. First it waits a programmable number of clocks. Then it asks for a precharge of all banks, a fixed number of auto refreshes spaced by the row cycle time, and one load of the mode register. It pulses a one-cycle command strobe with an opcode for each step and raises a done flag once the mode register settling time has elapsed.

Once done is high, an interval counter meters out refresh requests. A 2048-row array with a 32 ms retention budget needs one auto refresh about every 15.6 µs, which is 1560 clocks at 100 MHz. Each expiry of the interval adds one request to a small backlog. The request output stays high while the backlog is non-empty. Each acknowledge from the command sequencer retires one entry. The sequencer must only acknowledge when both banks are precharged, because an auto refresh closes its rows internally and needs no precharge after it. If an interval expires while the backlog is already full, a sticky overrun flag records the missed deadline.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted, refresh_req, init_cmd_valid, init_done and refresh_overrun are all 0 and init_cmd_op is 0.
- R2: The precharge-all strobe (init_cmd_valid=1, init_cmd_op=1) appears exactly SYNC_STAGES+POWERUP_CLKS cycles after reset is released.
- R3: Exactly INIT_REFRESHES auto-refresh strobes (init_cmd_op=2) follow. The first comes TRC_CLKS cycles after the precharge strobe, and each later one comes TRC_CLKS cycles after the previous one.
- R4: The load-mode strobe (init_cmd_op=3) comes TRC_CLKS cycles after the last auto-refresh strobe. init_done rises MRS_WAIT_CLKS cycles after it and stays high until reset.
- R5: Every init strobe lasts one cycle. init_cmd_op is 0 whenever init_cmd_valid is 0. No init strobe occurs once init_done is high.
- R6: refresh_req stays 0 before init_done. An acknowledge given before init_done has no effect.
- R7: The first refresh request appears REFRESH_INTERVAL cycles after init_done rises. The interval counter restarts each time a request is added, whatever the acknowledge timing.
- R8: refresh_req stays high until every pending request has been acknowledged, one acknowledge per clock. When an acknowledge and a new request fall on the same clock, the backlog is unchanged.
- R9: An acknowledge given while no request is pending is ignored: the backlog does not wrap, and the next interval yields exactly one request.
- R10: If an interval expires while BACKLOG_LIMIT requests are pending and no acknowledge is given, refresh_overrun is set and stays set until reset. The backlog stays at BACKLOG_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in sync with clk |
| refresh_ack | input | 1 | Command sequencer has issued one auto refresh |
| refresh_req | output | 1 | At least one periodic refresh is pending |
| init_cmd_valid | output | 1 | One-cycle strobe for an initialisation command |
| init_cmd_op | output | 2 | Init opcode: 0 idle, 1 precharge all, 2 auto refresh, 3 load mode |
| init_done | output | 1 | Initialisation complete; host traffic may start |
| refresh_overrun | output | 1 | Sticky flag: an interval expired with the backlog full |

## Verification
The bench follows every clock from reset release in a reduced configuration and checks the exact cycle of each init strobe. A design that miscounts the power-up wait, the spacing of the auto refreshes or the mode-register settle shows up as a strobe or a done edge one cycle off. The bench acknowledges before done and with an empty backlog, to expose a design whose backlog counter wraps or that requests refresh too early. It lets the backlog fill to its limit and then retires an entry on the very clock a new request arrives, which catches a design that drops or double-counts on the coincident edge. Finally it lets the limit be exceeded, so that a design that never raises the overrun flag, clears it, or lets the backlog grow past the limit gives the wrong flag or the wrong request count.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

  typedef enum logic [1:0] {
    OP_IDLE          = 2'd0,
    OP_PRECHARGE_ALL = 2'd1,
    OP_AUTO_REFRESH  = 2'd2,
    OP_LOAD_MODE     = 2'd3
  } init_op_e;

  typedef enum logic [2:0] {
    ST_POWER_WAIT,
    ST_PRECHARGE,
    ST_REFRESH,
    ST_LOAD_MODE,
    ST_READY
  } init_state_e;

endpackage

// File: rtl/sched_reset_sync.sv
module sched_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sched_init_seq.sv
module sched_init_seq
  import sdram_sched_pkg::*;
#(
  parameter int POWERUP_CLKS   = 10000,
  parameter int TRC_CLKS       = 7,
  parameter int INIT_REFRESHES = 8,
  parameter int MRS_WAIT_CLKS  = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  output logic     cmd_valid,
  output init_op_e cmd_op,
  output logic     done
);

  localparam int CMAX_A = (POWERUP_CLKS > TRC_CLKS) ? POWERUP_CLKS : TRC_CLKS;
  localparam int CMAX   = (CMAX_A > MRS_WAIT_CLKS) ? CMAX_A : MRS_WAIT_CLKS;
  localparam int CW     = $clog2(CMAX + 1);
  localparam int NW     = $clog2(INIT_REFRESHES + 1);
  localparam logic [CW-1:0] PWR_LAST = CW'(POWERUP_CLKS - 1);
  localparam logic [CW-1:0] TRC_LAST = CW'(TRC_CLKS - 1);
  localparam logic [CW-1:0] MRS_LAST = CW'(MRS_WAIT_CLKS - 1);
  localparam logic [NW-1:0] REF_LAST = NW'(INIT_REFRESHES - 1);

  init_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] nref_q, nref_d;
  logic          step_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + 1'b1;
    nref_d    = nref_q;
    cmd_valid = 1'b0;
    cmd_op    = OP_IDLE;
    case (state_q)
      ST_POWER_WAIT: begin
        if (cnt_q == PWR_LAST) begin
          state_d = ST_PRECHARGE;
          cnt_d   = '0;
        end
      end
      ST_PRECHARGE: begin
        if (cnt_q == '0) begin
          cmd_valid = 1'b1;
          cmd_op    = OP_PRECHARGE_ALL;
        end
        if (cnt_q == TRC_LAST) begin
          state_d = ST_REFRESH;
          cnt_d   = '0;
          nref_d  = '0;
        end
      end
      ST_REFRESH: begin
        if (cnt_q == '0) begin
          cmd_valid = 1'b1;
          cmd_op    = OP_AUTO_REFRESH;
        end
        if (cnt_q == TRC_LAST) begin
          cnt_d = '0;
          if (nref_q == REF_LAST) state_d = ST_LOAD_MODE;
          else                    nref_d  = nref_q + 1'b1;
        end
      end
      ST_LOAD_MODE: begin
        if (cnt_q == '0) begin
          cmd_valid = 1'b1;
          cmd_op    = OP_LOAD_MODE;
        end
        if (cnt_q == MRS_LAST) begin
          state_d = ST_READY;
          cnt_d   = '0;
        end
      end
      default: cnt_d = cnt_q;
    endcase
  end

  assign step_en = (state_q != ST_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWER_WAIT;
      cnt_q   <= '0;
      nref_q  <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nref_q  <= nref_d;
    end
  end

  assign done = (state_q == ST_READY);

endmodule

// File: rtl/sched_refresh_timer.sv
module sched_refresh_timer #(
  parameter int INTERVAL      = 1560,
  parameter int BACKLOG_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic req,
  output logic overrun
);

  localparam int IW = $clog2(INTERVAL);
  localparam int BW = $clog2(BACKLOG_LIMIT + 1);
  localparam logic [IW-1:0] INT_LAST = IW'(INTERVAL - 1);
  localparam logic [BW-1:0] PEND_MAX = BW'(BACKLOG_LIMIT);

  logic [IW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] pend_q, pend_d;
  logic          ovr_q, ovr_d;
  logic          tick, take, pend_en;

  assign tick = enable && (cnt_q == INT_LAST);
  assign take = ack && (pend_q != '0);

  always_comb begin
    cnt_d   = tick ? '0 : cnt_q + 1'b1;
    pend_d  = pend_q;
    ovr_d   = ovr_q;
    pend_en = 1'b0;
    if (tick && !take) begin
      if (pend_q == PEND_MAX) begin
        ovr_d = 1'b1;
      end else begin
        pend_d  = pend_q + 1'b1;
        pend_en = 1'b1;
      end
    end else if (!tick && take) begin
      pend_d  = pend_q - 1'b1;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (enable) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovr_q <= 1'b0;
    else if (tick) ovr_q <= ovr_d;
  end

  assign req     = (pend_q != '0);
  assign overrun = ovr_q;

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_sched_pkg::*;
#(
  parameter int POWERUP_CLKS     = 10000,
  parameter int TRC_CLKS         = 7,
  parameter int INIT_REFRESHES   = 8,
  parameter int MRS_WAIT_CLKS    = 2,
  parameter int REFRESH_INTERVAL = 1560,
  parameter int BACKLOG_LIMIT    = 8,
  parameter int SYNC_STAGES      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh_ack,
  output logic       refresh_req,
  output logic       init_cmd_valid,
  output logic [1:0] init_cmd_op,
  output logic       init_done,
  output logic       refresh_overrun
);

  logic     rst_int_n;
  init_op_e seq_op;

  sched_reset_sync #(
    .STAGES(SYNC_STAGES)
  ) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  sched_init_seq #(
    .POWERUP_CLKS  (POWERUP_CLKS),
    .TRC_CLKS      (TRC_CLKS),
    .INIT_REFRESHES(INIT_REFRESHES),
    .MRS_WAIT_CLKS (MRS_WAIT_CLKS)
  ) i_init_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_valid(init_cmd_valid),
    .cmd_op   (seq_op),
    .done     (init_done)
  );

  sched_refresh_timer #(
    .INTERVAL     (REFRESH_INTERVAL),
    .BACKLOG_LIMIT(BACKLOG_LIMIT)
  ) i_refresh_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .enable (init_done),
    .ack    (refresh_ack),
    .req    (refresh_req),
    .overrun(refresh_overrun)
  );

  assign init_cmd_op = seq_op;

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       refresh_ack,
  input logic       refresh_req,
  input logic       init_cmd_valid,
  input logic [1:0] init_cmd_op,
  input logic       init_done,
  input logic       refresh_overrun
);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd_valid |=> !init_cmd_valid);

  // R5
  op_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_cmd_valid |-> (init_cmd_op == 2'd0));

  // R5
  no_cmd_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !init_cmd_valid);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R6
  no_early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

  // R10
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_overrun |=> refresh_overrun);

  // R10
  overrun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_overrun) |-> refresh_req);

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk i_chk (.*);

// File: tb/test_sdram_refresh_sched.sv
`timescale 1ns/1ps
module test_sdram_refresh_sched;

  localparam int P  = 20;
  localparam int T  = 3;
  localparam int N  = 3;
  localparam int M  = 2;
  localparam int I  = 16;
  localparam int L  = 3;
  localparam int S  = 2;
  localparam int P0    = S + P;
  localparam int LOADK = P0 + T * (N + 1);
  localparam int D     = LOADK + M;
  localparam int LAST  = D + 12 * I + 2;

  logic       clk;
  logic       rst_n;
  logic       refresh_ack;
  logic       refresh_req;
  logic       init_cmd_valid;
  logic [1:0] init_cmd_op;
  logic       init_done;
  logic       refresh_overrun;

  int  n_cmp;
  int  n_bad;
  bit  finished;

  sdram_refresh_sched #(
    .POWERUP_CLKS    (P),
    .TRC_CLKS        (T),
    .INIT_REFRESHES  (N),
    .MRS_WAIT_CLKS   (M),
    .REFRESH_INTERVAL(I),
    .BACKLOG_LIMIT   (L),
    .SYNC_STAGES     (S)
  ) i_sdram_refresh_sched (
    .clk            (clk),
    .rst_n          (rst_n),
    .refresh_ack    (refresh_ack),
    .refresh_req    (refresh_req),
    .init_cmd_valid (init_cmd_valid),
    .init_cmd_op    (init_cmd_op),
    .init_done      (init_done),
    .refresh_overrun(refresh_overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  function automatic bit ack_plan(input int k, input int pend);
    int r;
    r = k - D;
    if (k < D) return (k == 5) || (k == 30);
    if (r < 4 * I + 4) return (pend > 0) && ((r % I) == 3);
    if (r < 7 * I) return 1'b0;
    if (r < 8 * I) return (r == 7 * I + 2) || (r == 7 * I + 3) || (r == 8 * I - 1);
    if (r >= 11 * I + 2 && r < 11 * I + 7) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    n_cmp = 0;
    n_bad = 0;
    finished = 1'b0;
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int  pend_m;
    bit  ovr_m;
    rst_n = 1'b0;
    refresh_ack = 1'b0;
    pend_m = 0;
    ovr_m = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(refresh_req == 1'b0, "R1 req", int'(refresh_req), 0);
    check(init_cmd_valid == 1'b0 && init_cmd_op == 2'd0, "R1 cmd",
          int'({init_cmd_valid, init_cmd_op}), 0);
    check(init_done == 1'b0, "R1 done", int'(init_done), 0);
    check(refresh_overrun == 1'b0, "R1 overrun", int'(refresh_overrun), 0);
    rst_n = 1'b1;
    for (int k = 0; k <= LAST; k++) begin
      int    exp_cmd;
      int    act_cmd;
      int    r;
      string tag;
      bit    a;
      bit    tick;
      bit    take;
      r = k - D;
      // init strobe: R2 precharge, R3 refreshes, R4 load mode, R5 idle
      if (k == P0) begin
        exp_cmd = 4 + 1; tag = "R2 cmd";
      end else if (k >= P0 + T && k <= P0 + T * N && ((k - P0) % T) == 0) begin
        exp_cmd = 4 + 2; tag = "R3 cmd";
      end else if (k == LOADK) begin
        exp_cmd = 4 + 3; tag = "R4 cmd";
      end else begin
        exp_cmd = 0; tag = "R5 cmd";
      end
      act_cmd = int'({init_cmd_valid, init_cmd_op});
      check(act_cmd == exp_cmd, tag, act_cmd, exp_cmd);
      // R4 done edge and hold
      check(init_done == (k >= D), "R4 done", int'(init_done), int'(k >= D));
      // refresh request
      if (k < D) tag = "R6 req";
      else if (r == I - 1 || r == I) tag = "R7 req";
      else if (r >= 11 * I + 5 && r <= 12 * I) tag = "R9 req";
      else tag = "R8 req";
      check(refresh_req == (pend_m != 0), tag, int'(refresh_req), int'(pend_m != 0));
      // R10 overrun flag
      check(refresh_overrun == ovr_m, "R10 overrun", int'(refresh_overrun), int'(ovr_m));
      a = ack_plan(k, pend_m);
      refresh_ack = a;
      tick = (k + 1 - D > 0) && (((k + 1 - D) % I) == 0);
      take = a && (pend_m > 0);
      if (tick && !take) begin
        if (pend_m == L) ovr_m = 1'b1;
        else pend_m++;
      end else if (!tick && take) begin
        pend_m--;
      end
      @(negedge clk);
    end
    refresh_ack = 1'b0;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule